// File: doc/BRIEF.md
# Complement-Protected Safety Mode Register

This block keeps a two-valued operating mode, either safe or hazard-enabled, in a form that a bit flip cannot silently turn from one into the other. Each mode is held as an 8-bit pattern. A second register holds the bitwise inverse of the first. On every cycle a checker confirms two things: the primary register holds one of the two legal patterns, and the second register is its exact inverse. If either test fails, both registers are rewritten with the safe pattern and a flag is latched that stays set until reset.

An external controller decides when a mode change is allowed. It asks for a change by presenting a pattern on the request port. Returning to safe takes a single presentation. Entering the hazard-enabled mode needs the hazard pattern on two consecutive cycles. Any other pattern presented as a request is ignored and reported.

Two error-injection masks can be XORed into the stored copies at the clock edge. They model upsets in storage, so that the detection path can be exercised at the ports.

Top module: `crit_mode_reg`

## Requirements
- R1: After reset, both copies hold the safe pattern, `mode_hazard_o`, `corrupt_o` and `reject_o` are low, and a later reset clears a latched `corrupt_o`.
- R2: The safe pattern is 8'hA5, the hazard pattern is 8'h5A (its bitwise inverse), and the second copy always holds the bitwise inverse of the primary. If both copies of a safe register are inverted, the result decodes as hazard-enabled without a corruption report. A two-bit upset of the safe primary decodes as not hazardous.
- R3: When `req_valid_i` is high with code 8'h5A on two consecutive cycles, `mode_hazard_o` rises in the cycle after the second of them. Holding the request longer keeps the mode.
- R4: A single 8'h5A request, or two separated by an idle cycle, does not change the mode.
- R5: A request with code 8'hA5 returns the mode to safe, visible the cycle after one presentation.
- R6: A valid request whose code is neither 8'hA5 nor 8'h5A leaves the mode unchanged. It raises `reject_o` for one cycle, in the cycle that follows. It also breaks a pending pair of hazard requests. When `req_valid_i` is low, the code is ignored and nothing is rejected.
- R7: When the primary is not a legal pattern, or the copies are not inverses, both copies are rewritten with the safe pattern one cycle later and `corrupt_o` is set.
- R8: `corrupt_o` stays set until reset. While it is set, hazard requests are ignored.
- R9: `mode_hazard_o` is high only while the primary equals 8'h5A and the second copy equals 8'hA5. It therefore drops in the same cycle that a storage upset is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Mode-change request strobe |
| req_code_i | input | 8 | Requested mode pattern |
| upset_pri_i | input | 8 | Error-injection mask XORed into the primary copy at the edge |
| upset_cpy_i | input | 8 | Error-injection mask XORed into the inverse copy at the edge |
| mode_hazard_o | output | 1 | Decoded mode: high when hazard-enabled and consistent |
| corrupt_o | output | 1 | Sticky corruption flag |
| reject_o | output | 1 | One-cycle report of an illegal request code |

## Verification
The assertions check several properties on every cycle. A detected fault always leads to a safe, flagged state on the next cycle. The corruption flag never clears on its own. A rise of the decoded mode is always preceded by two hazard requests. An illegal request never moves the mode, and a safe request always lands. The bench scenarios have to show the rest: the actual pattern values and their inverse relation, which they reveal through the double-inversion upset. They also cover how an idle or illegal cycle breaks a hazard pair, the same-cycle drop of the decoded output under a copy upset, and the lockout of hazard requests after corruption.

// File: rtl/crit_mode_pkg.sv
package crit_mode_pkg;

    localparam int unsigned MODE_W = 8;

    typedef logic [MODE_W-1:0] pat_t;

    localparam pat_t SAFE_PAT = 8'hA5;
    localparam pat_t HAZ_PAT  = ~SAFE_PAT;

    typedef struct packed {
        pat_t pri;
        pat_t cpy;
        logic armed;
        logic corrupt;
        logic reject;
    } mode_st_t;

endpackage

// File: rtl/crit_mode_integ.sv
module crit_mode_integ
    import crit_mode_pkg::*;
(
    input  pat_t pri_i,
    input  pat_t cpy_i,
    output logic fault_o,
    output logic haz_o
);

    logic [MODE_W-1:0] pair_bad;
    logic              legal;

    for (genvar g = 0; g < MODE_W; g++) begin : g_pair
        assign pair_bad[g] = ~(pri_i[g] ^ cpy_i[g]);
    end

    always_comb begin
        legal   = (pri_i == SAFE_PAT) || (pri_i == HAZ_PAT);
        fault_o = !legal || (|pair_bad);
        haz_o   = (pri_i == HAZ_PAT) && !(|pair_bad);
    end

endmodule

// File: rtl/crit_mode_reqq.sv
module crit_mode_reqq
    import crit_mode_pkg::*;
(
    input  logic valid_i,
    input  pat_t code_i,
    input  logic armed_i,
    input  logic lock_i,
    output logic go_safe_o,
    output logic go_haz_o,
    output logic arm_next_o,
    output logic bad_o
);

    logic is_safe;
    logic is_haz;

    always_comb begin
        is_safe    = (code_i == SAFE_PAT);
        is_haz     = (code_i == HAZ_PAT);
        bad_o      = valid_i && !is_safe && !is_haz;
        go_safe_o  = valid_i && is_safe;
        arm_next_o = valid_i && is_haz && !lock_i;
        go_haz_o   = arm_next_o && armed_i;
    end

endmodule

// File: rtl/crit_mode_reg.sv
module crit_mode_reg
    import crit_mode_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [MODE_W-1:0] req_code_i,
    input  logic [MODE_W-1:0] upset_pri_i,
    input  logic [MODE_W-1:0] upset_cpy_i,
    output logic              mode_hazard_o,
    output logic              corrupt_o,
    output logic              reject_o
);

    mode_st_t st_d, st_q;

    logic fault, haz_ok;
    logic go_safe, go_haz, arm_next, bad_req;
    logic no_upset;

    crit_mode_integ u_integ (
        .pri_i   (st_q.pri),
        .cpy_i   (st_q.cpy),
        .fault_o (fault),
        .haz_o   (haz_ok)
    );

    crit_mode_reqq u_reqq (
        .valid_i    (req_valid_i),
        .code_i     (req_code_i),
        .armed_i    (st_q.armed),
        .lock_i     (st_q.corrupt),
        .go_safe_o  (go_safe),
        .go_haz_o   (go_haz),
        .arm_next_o (arm_next),
        .bad_o      (bad_req)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reject = bad_req;
        st_d.armed  = arm_next;
        if (fault) begin
            st_d.pri     = SAFE_PAT;
            st_d.cpy     = ~SAFE_PAT;
            st_d.corrupt = 1'b1;
            st_d.armed   = 1'b0;
        end else if (go_safe) begin
            st_d.pri = SAFE_PAT;
            st_d.cpy = ~SAFE_PAT;
        end else if (go_haz) begin
            st_d.pri = HAZ_PAT;
            st_d.cpy = ~HAZ_PAT;
        end
        st_d.pri = st_d.pri ^ upset_pri_i;
        st_d.cpy = st_d.cpy ^ upset_cpy_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pri: SAFE_PAT, cpy: ~SAFE_PAT, armed: 1'b0,
                      corrupt: 1'b0, reject: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_hazard_o = haz_ok;
    assign corrupt_o     = st_q.corrupt;
    assign reject_o      = st_q.reject;
    assign no_upset      = (upset_pri_i == '0) && (upset_cpy_i == '0);

    a_r7_fault_to_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault && no_upset) |=> (!fault && !mode_hazard_o && corrupt_o));

    a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        corrupt_o |=> corrupt_o);

    a_r8_locked_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (corrupt_o && !mode_hazard_o && no_upset) |=> !mode_hazard_o);

    a_r3_two_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(mode_hazard_o) && $past(no_upset)) |->
        ($past(req_valid_i) && $past(req_code_i) == HAZ_PAT &&
         $past(req_valid_i, 2) && $past(req_code_i, 2) == HAZ_PAT));

    a_r6_bad_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bad_req && !fault && no_upset) |=> (reject_o && $stable(mode_hazard_o)));

    a_r5_safe_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_code_i == SAFE_PAT && no_upset) |=> !mode_hazard_o);

endmodule

// File: tb/crit_mode_reg_tb_top.sv
`timescale 1ns/1ps
module crit_mode_reg_tb_top;

    localparam logic [7:0] SAFE = 8'hA5;
    localparam logic [7:0] HAZ  = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_code = '0;
    logic [7:0] up_pri = '0;
    logic [7:0] up_cpy = '0;
    logic       haz, corrupt, reject;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    crit_mode_reg dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .req_valid_i   (req_valid),
        .req_code_i    (req_code),
        .upset_pri_i   (up_pri),
        .upset_cpy_i   (up_cpy),
        .mode_hazard_o (haz),
        .corrupt_o     (corrupt),
        .reject_o      (reject)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] c,
                         input logic [7:0] mp, input logic [7:0] mc);
        @(negedge clk);
        req_valid = v; req_code = c; up_pri = mp; up_cpy = mc;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_code = '0; up_pri = '0; up_cpy = '0;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 hazard after reset", haz, 1'b0);
        chk("R1 corrupt after reset", corrupt, 1'b0);
        chk("R1 reject after reset", reject, 1'b0);
    endtask

    task automatic t_enter();
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R3 one request", haz, 1'b0);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R3 two requests", haz, 1'b1);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R3 held request", haz, 1'b1);
        chk("R3 no corruption", corrupt, 1'b0);
    endtask

    task automatic t_safe();
        drive(1'b1, SAFE, 8'h00, 8'h00);
        chk("R5 safe request", haz, 1'b0);
    endtask

    task automatic t_split();
        drive(1'b1, HAZ, 8'h00, 8'h00);
        idle();
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R4 split pair", haz, 1'b0);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R4 fresh pair", haz, 1'b1);
        drive(1'b1, SAFE, 8'h00, 8'h00);
    endtask

    task automatic t_bad();
        drive(1'b1, 8'h00, 8'h00, 8'h00);
        chk("R6 reject pulse", reject, 1'b1);
        chk("R6 mode unchanged", haz, 1'b0);
        idle();
        chk("R6 reject one cycle", reject, 1'b0);
        drive(1'b0, 8'h3C, 8'h00, 8'h00);
        chk("R6 invalid code not rejected", reject, 1'b0);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        drive(1'b1, 8'h3C, 8'h00, 8'h00);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R6 bad code breaks pair", haz, 1'b0);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R6 pair after break", haz, 1'b1);
        drive(1'b1, 8'hFF, 8'h00, 8'h00);
        chk("R6 hazard kept on bad code", haz, 1'b1);
        chk("R6 reject while hazardous", reject, 1'b1);
        drive(1'b1, SAFE, 8'h00, 8'h00);
    endtask

    task automatic t_encoding();
        drive(1'b0, 8'h00, 8'hFF, 8'hFF);
        chk("R2 inverted pair decodes hazard", haz, 1'b1);
        idle();
        chk("R2 inverted pair not corrupt", corrupt, 1'b0);
        drive(1'b1, SAFE, 8'h00, 8'h00);
        drive(1'b0, 8'h00, 8'h03, 8'h00);
        chk("R2 two-bit upset not hazard", haz, 1'b0);
        idle();
        chk("R7 two-bit upset flagged", corrupt, 1'b1);
    endtask

    task automatic t_upset();
        do_reset();
        drive(1'b1, HAZ, 8'h00, 8'h00);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R3 enter before upset", haz, 1'b1);
        drive(1'b0, 8'h00, 8'h00, 8'h01);
        chk("R9 copy upset drops mode", haz, 1'b0);
        chk("R7 flag not yet set", corrupt, 1'b0);
        idle();
        chk("R7 flag set", corrupt, 1'b1);
        chk("R7 safe after rewrite", haz, 1'b0);
        do_reset();
        drive(1'b0, 8'h00, 8'hFF, 8'h00);
        chk("R9 primary-only flip not hazard", haz, 1'b0);
        idle();
        chk("R7 mismatch flagged", corrupt, 1'b1);
    endtask

    task automatic t_sticky();
        drive(1'b1, HAZ, 8'h00, 8'h00);
        drive(1'b1, HAZ, 8'h00, 8'h00);
        chk("R8 hazard locked out", haz, 1'b0);
        drive(1'b1, SAFE, 8'h00, 8'h00);
        idle();
        chk("R8 flag sticky", corrupt, 1'b1);
        do_reset();
        chk("R1 reset clears flag", corrupt, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_enter();
        t_safe();
        t_split();
        t_bad();
        t_encoding();
        t_upset();
        t_sticky();
        finish_run();
    end

endmodule